// File: doc/BRIEF.md
# Stepwise Unsigned Multiply Unit

This block multiplies two unsigned operands a few bits at a time, driven by commands. An init command names a multiplicand register and a multiplier register, loads their values, and clears an implicit accumulator. Each later step command takes the lowest 8 bits still left in the multiplicand. It forms their product with the multiplier, shifts that product left by 8 bits for every step already done since init, and adds it into the result. The caller issues one to four steps, which gives an 8-, 16-, 24- or 32-bit multiplicand.

There are two step variants. The narrow variant keeps a 32-bit result in the accumulator and drops any overflow. The wide variant keeps a 64-bit result: the low half sits in the accumulator and the high half sits in the multiplier register. Inside the block, a step is done as a serial shift-add over 8 cycles, one multiplicand bit per cycle. A one-cycle done pulse marks the end of each step. Commands that break the sequence rules are rejected and set a sticky error flag.

Top module: `smul_unit`

## Requirements
- R1: After reset, acc_o, hi_o and mcand_o are zero, and busy_o, done_o and err_o are low.
- R2: A command is accepted on a rising clock edge where cmd_valid_i is high and busy_o is low. Opcode 2'b01 is init. An accepted init with valid selects sets acc_o to 0, mcand_o to cmd_a_i and hi_o to cmd_b_i.
- R3: Opcode 2'b10 is a narrow step. It adds (multiplier × mcand_o[7:0]) << 8k to acc_o, modulo 2^32, where k is the number of steps done since the last init. It then shifts mcand_o right by 8 and leaves hi_o unchanged.
- R4: Opcode 2'b11 is a wide step. It adds the same shifted partial product to the 64-bit value {hi_o, acc_o}. On the first wide step after an init, the high half is taken as zero, not as the multiplier.
- R5: Take multiplicand A, multiplier B and n steps of one variant, with n from 1 to 4. Afterwards acc_o holds the low 32 bits of B × (A mod 2^(8n)). With wide steps, hi_o holds the high 32 bits of that product.
- R6: busy_o rises on the edge that accepts a step and stays high for 8 cycles. done_o is high for exactly one cycle, beginning 8 edges after the accept edge. The step's results appear on the same edge that raises done_o.
- R7: A command presented while busy_o is high has no effect. A command with opcode 2'b00 has no effect.
- R8: A step that arrives with no valid init since reset sets err_o and changes no output.
- R9: A step whose multiplicand or multiplier select differs from the one given at init sets err_o and changes no output.
- R10: An init whose select is 0, or whose two selects are equal, sets err_o and changes no result. It also cancels the running sequence, so later steps are rejected.
- R11: err_o stays high until reset, even when valid commands follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_op_i | input | 2 | Opcode: 00 none, 01 init, 10 narrow step, 11 wide step |
| cmd_ra_i | input | 3 | Multiplicand register select |
| cmd_rb_i | input | 3 | Multiplier register select |
| cmd_a_i | input | 32 | Multiplicand value, used by init |
| cmd_b_i | input | 32 | Multiplier value, used by init |
| busy_o | output | 1 | Step in progress |
| done_o | output | 1 | One-cycle pulse at step completion |
| err_o | output | 1 | Sticky sequence error |
| acc_o | output | 32 | Accumulator (result, low half) |
| hi_o | output | 32 | Multiplier register (high half after wide steps) |
| mcand_o | output | 32 | Multiplicand register, remaining bytes |

## Verification
The checker properties place no limit on command traffic. They assume only that the accumulator and multiplicand change through init or step completion, and that the done pulse follows a full run of busy cycles. Any mix of valid, rejected or ignored commands must therefore keep them true. The stimulus sweeps edge and mixed operand values across every step count and both variants. It then applies on purpose each rule-breaking case: a missing init, mismatched selects, bad init selects, a command while busy, and the null opcode. It checks at the ports that none of these changed the results.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_INIT   = 2'b01,
    OP_STEP32 = 2'b10,
    OP_STEP64 = 2'b11
  } smul_op_e;
endpackage

// File: rtl/smul_seq_ctrl.sv
module smul_seq_ctrl
  import smul_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int STEPS = 4,
  localparam int K_W  = $clog2(STEPS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_op_i,
  input  logic [SEL_W-1:0] cmd_ra_i,
  input  logic [SEL_W-1:0] cmd_rb_i,
  input  logic             busy_i,
  input  logic             step_done_i,
  output logic             init_go_o,
  output logic             step_go_o,
  output logic             step_wide_o,
  output logic [K_W-1:0]   k_o,
  output logic             err_o
);
  smul_op_e         op;
  logic             cmd_ok, sel_bad, is_step, sel_match;
  logic             armed_q, err_q;
  logic [SEL_W-1:0] ra_q, rb_q;
  logic [K_W-1:0]   k_q;

  assign op        = smul_op_e'(cmd_op_i);
  assign cmd_ok    = cmd_valid_i && !busy_i;
  assign sel_bad   = (cmd_ra_i == '0) || (cmd_rb_i == '0) || (cmd_ra_i == cmd_rb_i);
  assign is_step   = (op == OP_STEP32) || (op == OP_STEP64);
  assign sel_match = armed_q && (cmd_ra_i == ra_q) && (cmd_rb_i == rb_q);

  assign init_go_o   = cmd_ok && (op == OP_INIT) && !sel_bad;
  assign step_go_o   = cmd_ok && is_step && sel_match;
  assign step_wide_o = (op == OP_STEP64);
  assign k_o         = k_q;
  assign err_o       = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      err_q   <= 1'b0;
      ra_q    <= '0;
      rb_q    <= '0;
      k_q     <= '0;
    end else begin
      if (cmd_ok && (op == OP_INIT)) begin
        if (sel_bad) begin
          armed_q <= 1'b0;
          err_q   <= 1'b1;
        end else begin
          armed_q <= 1'b1;
          ra_q    <= cmd_ra_i;
          rb_q    <= cmd_rb_i;
          k_q     <= '0;
        end
      end
      if (cmd_ok && is_step && !sel_match) err_q <= 1'b1;
      if (step_done_i && (k_q != K_W'(STEPS))) k_q <= k_q + 1'b1;
    end
  end
endmodule

// File: rtl/smul_shift_add.sv
module smul_shift_add #(
  parameter int DATA_W = 32,
  parameter int STEP_W = 8,
  localparam int PROD_W = DATA_W + STEP_W,
  localparam int CNT_W  = $clog2(STEP_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [STEP_W-1:0] byte_i,
  input  logic [DATA_W-1:0] mplier_i,
  output logic              busy_o,
  output logic              last_o,
  output logic [PROD_W-1:0] prod_o
);
  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [STEP_W-1:0] byte_q;
  logic [PROD_W-1:0] part_q, part_nxt;

  // one multiplicand bit per cycle
  assign part_nxt = part_q + (byte_q[cnt_q] ? (PROD_W'(mplier_i) << cnt_q) : '0);
  assign last_o   = busy_q && (cnt_q == CNT_W'(STEP_W - 1));
  assign busy_o   = busy_q;
  assign prod_o   = part_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      byte_q <= '0;
      part_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      byte_q <= byte_i;
      part_q <= '0;
    end else if (busy_q) begin
      part_q <= part_nxt;
      cnt_q  <= cnt_q + 1'b1;
      if (last_o) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/smul_unit.sv
module smul_unit
  import smul_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STEP_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [SEL_W-1:0]  cmd_ra_i,
  input  logic [SEL_W-1:0]  cmd_rb_i,
  input  logic [DATA_W-1:0] cmd_a_i,
  input  logic [DATA_W-1:0] cmd_b_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] hi_o,
  output logic [DATA_W-1:0] mcand_o
);
  localparam int STEPS  = DATA_W / STEP_W;
  localparam int K_W    = $clog2(STEPS + 1);
  localparam int PROD_W = DATA_W + STEP_W;
  localparam int WIDE_W = 2 * DATA_W;
  localparam int SH_W   = $clog2(STEPS * STEP_W + 1);

  logic              init_go, step_go, step_wide, core_busy, core_last;
  logic [K_W-1:0]    k;
  logic [PROD_W-1:0] prod;
  logic [SH_W-1:0]   shamt;
  logic [WIDE_W-1:0] addend, wide_sum;
  logic [DATA_W-1:0] narrow_sum, hi_eff;
  logic [DATA_W-1:0] acc_q, hi_q, mcand_q, mplier_q;
  logic              wide_q, hi_zero_q, done_q;

  smul_seq_ctrl #(.SEL_W(SEL_W), .STEPS(STEPS)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .cmd_ra_i    (cmd_ra_i),
    .cmd_rb_i    (cmd_rb_i),
    .busy_i      (core_busy),
    .step_done_i (core_last),
    .init_go_o   (init_go),
    .step_go_o   (step_go),
    .step_wide_o (step_wide),
    .k_o         (k),
    .err_o       (err_o)
  );

  smul_shift_add #(.DATA_W(DATA_W), .STEP_W(STEP_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (step_go),
    .byte_i   (mcand_q[STEP_W-1:0]),
    .mplier_i (mplier_q),
    .busy_o   (core_busy),
    .last_o   (core_last),
    .prod_o   (prod)
  );

  assign shamt      = SH_W'(32'(k) * STEP_W);
  assign addend     = WIDE_W'(prod) << shamt;
  assign hi_eff     = hi_zero_q ? '0 : hi_q;
  assign wide_sum   = {hi_eff, acc_q} + addend;
  assign narrow_sum = acc_q + addend[DATA_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      hi_q      <= '0;
      mcand_q   <= '0;
      mplier_q  <= '0;
      wide_q    <= 1'b0;
      hi_zero_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= core_last;
      if (init_go) begin
        acc_q     <= '0;
        mcand_q   <= cmd_a_i;
        hi_q      <= cmd_b_i;
        mplier_q  <= cmd_b_i;
        hi_zero_q <= 1'b1;
      end
      if (step_go) wide_q <= step_wide;
      if (core_last) begin
        mcand_q <= mcand_q >> STEP_W;
        if (wide_q) begin
          {hi_q, acc_q} <= wide_sum;
          hi_zero_q     <= 1'b0;
        end else begin
          acc_q <= narrow_sum;
        end
      end
    end
  end

  assign busy_o  = core_busy;
  assign done_o  = done_q;
  assign acc_o   = acc_q;
  assign hi_o    = hi_q;
  assign mcand_o = mcand_q;
endmodule

// File: rtl/smul_unit_chk.sv
module smul_unit_chk #(
  parameter int DATA_W = 32,
  parameter int STEP_W = 8,
  localparam int RUN_W = $clog2(STEP_W + 2)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [1:0]        cmd_op_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [DATA_W-1:0] acc_o,
  input logic [DATA_W-1:0] mcand_o
);
  logic [RUN_W-1:0] busy_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_run <= '0;
    else if (busy_o) busy_run <= busy_run + 1'b1;
    else busy_run <= '0;
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o) && !busy_o); // R6
  AST_STEP_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_run == RUN_W'(STEP_W)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R11
  AST_ACC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(acc_o) |-> done_o || $past(cmd_valid_i && cmd_op_i == 2'b01 && !busy_o)); // R8
  AST_MCAND_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mcand_o) |-> done_o || $past(cmd_valid_i && cmd_op_i == 2'b01 && !busy_o)); // R9
  AST_BUSY_HOLDS_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(acc_o) && $stable(mcand_o)); // R7
endmodule

bind smul_unit smul_unit_chk #(.DATA_W(DATA_W), .STEP_W(STEP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .acc_o       (acc_o),
  .mcand_o     (mcand_o)
);

// File: tb/smul_unit_tb.sv
module smul_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [1:0]  cmd_op_i = 2'b00;
  logic [2:0]  cmd_ra_i = '0;
  logic [2:0]  cmd_rb_i = '0;
  logic [31:0] cmd_a_i = '0;
  logic [31:0] cmd_b_i = '0;
  logic        busy_o, done_o, err_o;
  logic [31:0] acc_o, hi_o, mcand_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk_i = ~clk_i;

  smul_unit dut_i (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i, .cmd_ra_i, .cmd_rb_i,
    .cmd_a_i, .cmd_b_i, .busy_o, .done_o, .err_o, .acc_o, .hi_o, .mcand_o
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic issue(input logic [1:0] op, input logic [2:0] ra, input logic [2:0] rb,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_ra_i = ra; cmd_rb_i = rb;
    cmd_a_i = a; cmd_b_i = b;
    @(negedge clk_i);
    cmd_valid_i = 1'b0; cmd_op_i = 2'b00;
  endtask

  // accepted step: check R6 timing, return at the done cycle
  task automatic do_step(input logic [1:0] op);
    bit ok;
    issue(op, 3'd1, 3'd2, '0, '0);
    ok = busy_o && !done_o;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk_i);
      if (i < 8) ok &= busy_o && !done_o;
      else ok &= !busy_o && done_o;
    end
    chk(ok, "R6 step timing", {62'd0, busy_o, done_o}, 64'd1);
  endtask

  function automatic logic [31:0] val(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h0000_0001;
      3: return 32'h8000_0000;
      4: return 32'h1234_5678;
      default: return 32'hA5C3_0F96;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    chk(1'b0, "R6 watchdog expired", 64'd0, 64'd1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [63:0] p, m;
    logic [31:0] a, b, keep;
    do_reset();
    @(negedge clk_i);
    // R1
    chk(acc_o == 0 && hi_o == 0 && mcand_o == 0 && !busy_o && !done_o && !err_o,
        "R1 reset state", {acc_o, hi_o}, 64'd0);

    // R8: step before any init
    issue(2'b10, 3'd1, 3'd2, '0, '0);
    @(negedge clk_i);
    chk(err_o && !busy_o && acc_o == 0 && mcand_o == 0, "R8 step without init",
        {63'd0, err_o}, 64'd1);
    issue(2'b01, 3'd1, 3'd2, 32'h5, 32'h7);
    chk(err_o, "R11 error sticky after valid init", {63'd0, err_o}, 64'd1);
    do_reset();

    // main sweep: R2 R3 R4 R5
    for (int ia = 0; ia < 6; ia++) begin
      for (int ib = 0; ib < 6; ib++) begin
        for (int n = 1; n <= 4; n++) begin
          for (int w = 0; w < 2; w++) begin
            a = val(ia); b = val(ib);
            issue(2'b01, 3'd1, 3'd2, a, b);
            chk(acc_o == 0 && hi_o == b && mcand_o == a, "R2 init load",
                {acc_o, mcand_o}, {32'd0, a});
            for (int s = 0; s < n; s++) do_step(w ? 2'b11 : 2'b10);
            m = (n == 4) ? {32'd0, a} : {32'd0, a & ((32'd1 << (8 * n)) - 1)};
            p = {32'd0, b} * m;
            chk(acc_o == p[31:0], "R5 accumulator product", {32'd0, acc_o}, {32'd0, p[31:0]});
            if (w) chk(hi_o == p[63:32], "R4 wide high half", {32'd0, hi_o}, {32'd0, p[63:32]});
            else   chk(hi_o == b, "R3 narrow keeps multiplier", {32'd0, hi_o}, {32'd0, b});
            chk(mcand_o == ((n == 4) ? 32'd0 : (a >> (8 * n))), "R3 multiplicand shift",
                {32'd0, mcand_o}, {32'd0, (n == 4) ? 32'd0 : (a >> (8 * n))});
          end
        end
      end
    end
    chk(!err_o, "R8 no spurious error", {63'd0, err_o}, 64'd0);

    // R7: init issued while busy is ignored
    issue(2'b01, 3'd1, 3'd2, 32'h0000_0003, 32'h0101_0101);
    issue(2'b10, 3'd1, 3'd2, '0, '0);
    issue(2'b01, 3'd1, 3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    repeat (7) @(negedge clk_i);
    chk(acc_o == 32'h0303_0303 && mcand_o == 0 && !err_o, "R7 command while busy ignored",
        {32'd0, acc_o}, 64'h0303_0303);
    // R7: null opcode
    issue(2'b00, 3'd1, 3'd2, 32'h1, 32'h1);
    @(negedge clk_i);
    chk(acc_o == 32'h0303_0303 && !busy_o && !done_o, "R7 null opcode ignored",
        {32'd0, acc_o}, 64'h0303_0303);

    // R9: mismatched selects
    issue(2'b01, 3'd1, 3'd2, 32'h0000_00FF, 32'h10);
    issue(2'b11, 3'd1, 3'd3, '0, '0);
    @(negedge clk_i);
    chk(err_o && !busy_o && acc_o == 0 && mcand_o == 32'hFF && hi_o == 32'h10,
        "R9 mismatched select rejected", {63'd0, err_o}, 64'd1);
    do_reset();

    // R10: bad init selects
    issue(2'b01, 3'd1, 3'd2, 32'h0000_0002, 32'h0000_0009);
    do_step(2'b10);
    chk(acc_o == 32'd18, "R3 single narrow step", {32'd0, acc_o}, 64'd18);
    issue(2'b01, 3'd3, 3'd3, 32'h4, 32'h4);
    chk(err_o && acc_o == 32'd18 && hi_o == 32'd9, "R10 equal selects rejected",
        {32'd0, acc_o}, 64'd18);
    issue(2'b10, 3'd1, 3'd2, '0, '0);
    @(negedge clk_i);
    chk(!busy_o && acc_o == 32'd18, "R10 sequence cancelled", {32'd0, acc_o}, 64'd18);
    do_reset();
    issue(2'b01, 3'd0, 3'd2, 32'h4, 32'h4);
    chk(err_o && acc_o == 0 && mcand_o == 0, "R10 zero select rejected",
        {63'd0, err_o}, 64'd1);
    keep = hi_o;
    chk(keep == 0, "R10 zero select no load", {32'd0, keep}, 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule